// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block takes a raw asynchronous serial line and recovers characters from it. It is paced by a one-cycle sample tick that the surrounding logic issues at sixteen times the baud rate. The raw line first passes through a two-flop synchroniser. A tick-driven glitch filter then removes short pulses. The filtered line is watched for a falling edge that marks a start bit. Each edge restarts a sixteen-tick bit clock, so every bit of the character is sampled on the eighth tick of its period. Timing error can therefore build up only within one character.

A two-bit length select chooses seven, eight or nine data bits. The length is latched when the start edge is seen. Data arrives least significant bit first. The lower eight bits come out on a parallel output, and the ninth bit, when present, comes out on its own pin. A one-cycle valid strobe marks each finished character. A framing error flag pulses with that strobe when the stop bit is sampled low. The character outputs hold their value until the next character replaces them.

Top module: `uart_rx_front`

## Requirements
- R1: The filtered line takes a new level only after the synchronised input has shown that level on 3 consecutive sample ticks. A low or high pulse that covers 2 ticks or fewer causes no valid strobe and does not alter a data bit.
- R2: A falling edge of the filtered line while idle begins a character. If the filtered line is high again on the 8th tick after that edge, the receiver returns to idle and issues no strobe.
- R3: Each bit is sampled on the 8th tick of its 16-tick period, counted from the start edge. The bit clock restarts on every start edge, so back-to-back characters are received with no idle time after the stop bit.
- R4: `len_sel_i` selects the data length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, and 2'b10 or 2'b11 gives 9 bits. Bits are received least significant first. The select is captured at the start edge, and later changes do not affect the character in progress.
- R5: `char_o` holds data bits 0..7. In 7-bit mode bit 7 of `char_o` is 0. `bit9_o` carries the ninth data bit in 9-bit mode and is 0 otherwise.
- R6: `vld_o` is high for exactly one clock cycle per received character. `char_o` and `bit9_o` keep their value until the next strobe.
- R7: `ferr_o` is 1 in the strobe cycle exactly when the stop bit was sampled low. It is never high without `vld_o`.
- R8: After reset, `vld_o`, `ferr_o`, `bit9_o` and `char_o` are all 0 and the receiver is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse at 16 times the baud rate |
| rx_i | input | 1 | Raw asynchronous serial line, idle high |
| len_sel_i | input | 2 | Data length select (7, 8 or 9 bits) |
| char_o | output | DATA_W | Received data bits 0..7 |
| bit9_o | output | 1 | Ninth data bit in 9-bit mode |
| vld_o | output | 1 | One-cycle strobe per finished character |
| ferr_o | output | 1 | Framing error, with the strobe |

## Verification
The checker enforces several rules on every cycle. The filtered line never moves on a cycle without a tick. The strobe is never longer than one cycle and always follows a midpoint tick. The framing flag never appears alone. The outputs stay stable between strobes. A start edge always zeroes the bit clock. The unused upper bits are zero in the shorter modes. Only the bench's scenarios can show the rest: the rejection of short pulses on the idle line and inside a data bit, the abandonment of a false start, the correct bit order and length latching across a mid-character change of select, and clean reception of back-to-back and randomly spaced characters.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam logic [1:0] LEN_SHORT = 2'b00;
  localparam logic [1:0] LEN_BYTE  = 2'b01;

endpackage

// File: rtl/urx_line_cond.sv
module urx_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_raw,
  output logic line_f,
  output logic fall
);

  localparam int RUN_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_bit;
  logic [RUN_W-1:0]       run_q, run_d;
  logic                   filt_q, filt_d;
  logic                   prev_q;

  // synchroniser chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_raw};
    end
  end

  assign sync_bit = sync_q[SYNC_STAGES-1];

  // glitch filter: a level must persist for FILT_LEN ticks
  always_comb begin
    run_d  = run_q;
    filt_d = filt_q;
    if (tick) begin
      if (sync_bit != filt_q) begin
        if (run_q == RUN_W'(FILT_LEN - 1)) begin
          filt_d = sync_bit;
          run_d  = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      run_q  <= run_d;
      filt_q <= filt_d;
      prev_q <= filt_q;
    end
  end

  assign line_f = filt_q;
  assign fall   = prev_q & ~filt_q;

endmodule

// File: rtl/urx_bit_clock.sv
module urx_bit_clock #(
  parameter int OSR = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     restart,
  output logic                     mid,
  output logic                     last,
  output logic [$clog2(OSR)-1:0]   cnt_o
);

  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_IDX  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(OSR - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign mid   = tick & ~restart & (cnt_q == MID_IDX);
  assign last  = tick & ~restart & (cnt_q == LAST_IDX);
  assign cnt_o = cnt_q;

endmodule

// File: rtl/urx_frame_fsm.sv
module urx_frame_fsm
  import urx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              fall,
  input  logic              mid,
  input  logic              last,
  input  logic [1:0]        len_sel,
  output logic              restart,
  output logic [DATA_W-1:0] char_o,
  output logic              bit9_o,
  output logic              vld_o,
  output logic              ferr_o,
  output logic              nine_o,
  output logic              short_o
);

  localparam int MAX_BITS = DATA_W + 1;
  localparam int IDX_W    = $clog2(MAX_BITS);

  rx_state_e             state_q, state_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [IDX_W-1:0]      lidx_q, lidx_d;
  logic [MAX_BITS-1:0]   shf_q, shf_d;
  logic [DATA_W-1:0]     chr_q, chr_d;
  logic                  b9_q, b9_d;
  logic                  vld_q, vld_d;
  logic                  fe_q, fe_d;

  assign restart = (state_q == ST_IDLE) && fall;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    lidx_d  = lidx_q;
    shf_d   = shf_q;
    chr_d   = chr_q;
    b9_d    = b9_q;
    vld_d   = 1'b0;
    fe_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_d = ST_START;
          idx_d   = '0;
          shf_d   = '0;
          case (len_sel)
            LEN_SHORT: lidx_d = IDX_W'(DATA_W - 2);
            LEN_BYTE:  lidx_d = IDX_W'(DATA_W - 1);
            default:   lidx_d = IDX_W'(DATA_W);
          endcase
        end
      end
      ST_START: begin
        if (mid && line) begin
          state_d = ST_IDLE;
        end else if (last) begin
          state_d = ST_DATA;
          idx_d   = '0;
        end
      end
      ST_DATA: begin
        if (mid) begin
          shf_d[idx_q] = line;
        end
        if (last) begin
          if (idx_q == lidx_q) begin
            state_d = ST_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (mid) begin
          state_d = ST_IDLE;
          vld_d   = 1'b1;
          fe_d    = ~line;
          chr_d   = shf_q[DATA_W-1:0];
          b9_d    = shf_q[DATA_W];
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      lidx_q  <= IDX_W'(DATA_W - 1);
      shf_q   <= '0;
      chr_q   <= '0;
      b9_q    <= 1'b0;
      vld_q   <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      lidx_q  <= lidx_d;
      shf_q   <= shf_d;
      chr_q   <= chr_d;
      b9_q    <= b9_d;
      vld_q   <= vld_d;
      fe_q    <= fe_d;
    end
  end

  assign char_o  = chr_q;
  assign bit9_o  = b9_q;
  assign vld_o   = vld_q;
  assign ferr_o  = fe_q;
  assign nine_o  = (lidx_q == IDX_W'(DATA_W));
  assign short_o = (lidx_q == IDX_W'(DATA_W - 2));

endmodule

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
  parameter int OSR         = 16,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        len_sel_i,
  output logic [DATA_W-1:0] char_o,
  output logic              bit9_o,
  output logic              vld_o,
  output logic              ferr_o
);

  localparam int CNT_W = $clog2(OSR);

  logic [1:0]       rst_q;
  logic             rst_int_n;
  logic             line_f;
  logic             fall;
  logic             restart;
  logic             mid_tick;
  logic             last_tick;
  logic [CNT_W-1:0] bit_cnt;
  logic             nine_q;
  logic             short_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= '0;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_q[1];

  urx_line_cond #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_cond (
    .clk    (clk_i),
    .rst_n  (rst_int_n),
    .tick   (tick_i),
    .rx_raw (rx_i),
    .line_f (line_f),
    .fall   (fall)
  );

  urx_bit_clock #(
    .OSR(OSR)
  ) u_bclk (
    .clk     (clk_i),
    .rst_n   (rst_int_n),
    .tick    (tick_i),
    .restart (restart),
    .mid     (mid_tick),
    .last    (last_tick),
    .cnt_o   (bit_cnt)
  );

  urx_frame_fsm #(
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk     (clk_i),
    .rst_n   (rst_int_n),
    .line    (line_f),
    .fall    (fall),
    .mid     (mid_tick),
    .last    (last_tick),
    .len_sel (len_sel_i),
    .restart (restart),
    .char_o  (char_o),
    .bit9_o  (bit9_o),
    .vld_o   (vld_o),
    .ferr_o  (ferr_o),
    .nine_o  (nine_q),
    .short_o (short_q)
  );

endmodule

// File: rtl/urx_checks.sv
module urx_checks #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              line_f,
  input logic              restart,
  input logic              mid,
  input logic [CNT_W-1:0]  cnt,
  input logic              vld,
  input logic              ferr,
  input logic              bit9,
  input logic [DATA_W-1:0] chr,
  input logic              nine,
  input logic              short_len
);

  // R1: the filter only moves on a sample tick
  p_filt_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(line_f));

  // R3: a start edge zeroes the bit clock
  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R3: a strobe follows a midpoint tick
  p_vld_after_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld) |-> $past(mid));

  // R5: ninth bit is zero outside 9-bit mode
  p_bit9_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !nine) |-> !bit9);

  // R5: top data bit is zero in 7-bit mode
  p_short_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && short_len) |-> !chr[DATA_W-1]);

  // R6: strobe lasts one cycle
  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  // R6: character held between strobes
  p_char_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> ($stable(chr) && $stable(bit9)));

  // R7: framing flag only with the strobe
  p_ferr_with_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |-> vld);

endmodule

bind uart_rx_front urx_checks #(
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .tick      (tick_i),
  .line_f    (line_f),
  .restart   (restart),
  .mid       (mid_tick),
  .cnt       (bit_cnt),
  .vld       (vld_o),
  .ferr      (ferr_o),
  .bit9      (bit9_o),
  .chr       (char_o),
  .nine      (nine_q),
  .short_len (short_q)
);

// File: tb/sim_uart_rx_front.sv
module sim_uart_rx_front;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int OSR        = 16;
  localparam int DW         = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick = 1'b0;
  logic          rx;
  logic [1:0]    len_sel;
  logic [DW-1:0] char_o;
  logic          bit9_o, vld_o, ferr_o;

  int n_chk = 0, n_bad = 0;
  int n_vld = 0, n_dbl = 0, n_orph = 0;
  int div = 0;
  logic          prev_vld = 1'b0;
  logic [DW-1:0] cap_c = '0;
  logic          cap_b9 = 1'b0, cap_fe = 1'b0;

  uart_rx_front u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .rx_i      (rx),
    .len_sel_i (len_sel),
    .char_o    (char_o),
    .bit9_o    (bit9_o),
    .vld_o     (vld_o),
    .ferr_o    (ferr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (div == TICK_DIV - 1) begin
      div  <= 0;
      tick <= 1'b1;
    end else begin
      div  <= div + 1;
      tick <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (vld_o) begin
      n_vld++;
      cap_c  = char_o;
      cap_b9 = bit9_o;
      cap_fe = ferr_o;
    end
    if (vld_o && prev_vld) n_dbl++;
    if (ferr_o && !vld_o) n_orph++;
    prev_vld = vld_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!tick) @(negedge clk);
    end
  endtask

  function automatic logic [DW-1:0] exp_char(input logic [8:0] d, input int nb);
    return (nb == 7) ? {1'b0, d[6:0]} : d[7:0];
  endfunction

  function automatic logic exp_b9(input logic [8:0] d, input int nb);
    return (nb == 9) ? d[8] : 1'b0;
  endfunction

  function automatic logic [1:0] sel_for(input int nb, input logic alt);
    return (nb == 7) ? 2'b00 : (nb == 8) ? 2'b01 : {1'b1, alt};
  endfunction

  task automatic send(input logic [8:0] d, input int nb, input bit bad_stop,
                      input int gap, input int glitch_bit, input int switch_sel);
    rx = 1'b0;
    wait_ticks(OSR);
    if (switch_sel >= 0) len_sel = 2'(switch_sel);
    for (int i = 0; i < nb; i++) begin
      if (i == glitch_bit) begin
        rx = d[i];  wait_ticks(6);
        rx = ~d[i]; wait_ticks(2);
        rx = d[i];  wait_ticks(OSR - 8);
      end else begin
        rx = d[i];
        wait_ticks(OSR);
      end
    end
    rx = bad_stop ? 1'b0 : 1'b1;
    wait_ticks(OSR);
    rx = 1'b1;
    wait_ticks(gap);
  endtask

  task automatic rx_check(input string req, input logic [8:0] d, input int nb,
                          input bit bad_stop, input int gap, input int glitch_bit,
                          input int switch_sel, input int exp_nb);
    int base;
    base = n_vld;
    send(d, nb, bad_stop, gap, glitch_bit, switch_sel);
    chk({req, " strobe count"}, 32'(n_vld - base), 32'd1);
    chk({req, " char"}, 32'(cap_c), 32'(exp_char(d, exp_nb)));
    chk({req, " bit9"}, 32'(cap_b9), 32'(exp_b9(d, exp_nb)));
    chk({req, " ferr"}, 32'(cap_fe), 32'(bad_stop));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    logic [8:0] d;
    int nb;
    bit bad;
    void'($urandom(32'd20240611));
    rx      = 1'b1;
    len_sel = 2'b01;
    rst_n   = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: reset values
    chk("R8 vld", 32'(vld_o), 0);
    chk("R8 ferr", 32'(ferr_o), 0);
    chk("R8 bit9", 32'(bit9_o), 0);
    chk("R8 char", 32'(char_o), 0);
    wait_ticks(8);

    // R4 R5: directed lengths and bit order
    len_sel = 2'b01;
    rx_check("R4 8-bit A5", 9'h0A5, 8, 0, 6, -1, -1, 8);
    rx_check("R4 8-bit 3C", 9'h03C, 8, 0, 6, -1, -1, 8);
    len_sel = 2'b00;
    rx_check("R5 7-bit top zero", 9'h1FF, 7, 0, 6, -1, -1, 7);
    len_sel = 2'b10;
    rx_check("R5 9-bit b9 one", 9'h15A, 9, 0, 6, -1, -1, 9);
    len_sel = 2'b11;
    rx_check("R5 9-bit b9 zero", 9'h0C3, 9, 0, 6, -1, -1, 9);

    // R6: outputs held, no further strobe on an idle line
    base = n_vld;
    wait_ticks(20);
    chk("R6 no extra strobe", 32'(n_vld - base), 0);
    chk("R6 char held", 32'(char_o), 32'h0C3);

    // R7: framing error, then recovery
    len_sel = 2'b01;
    rx_check("R7 bad stop", 9'h081, 8, 1, 10, -1, -1, 8);
    rx_check("R7 good after bad", 9'h07E, 8, 0, 6, -1, -1, 8);

    // R1: short pulse on idle line
    base = n_vld;
    rx = 1'b0; wait_ticks(2);
    rx = 1'b1; wait_ticks(40);
    chk("R1 idle glitch ignored", 32'(n_vld - base), 0);
    // R1: short pulse inside a data bit
    rx_check("R1 glitch in bit 3", 9'h05A, 8, 0, 6, 3, -1, 8);
    rx_check("R1 glitch in bit 6", 9'h0B4, 8, 0, 6, 6, -1, 8);

    // R2: false start
    base = n_vld;
    rx = 1'b0; wait_ticks(5);
    rx = 1'b1; wait_ticks(40);
    chk("R2 false start dropped", 32'(n_vld - base), 0);
    rx_check("R2 good after false start", 9'h0E7, 8, 0, 6, -1, -1, 8);

    // R4: length captured at start edge
    len_sel = 2'b10;
    rx_check("R4 len latched", 9'h1A7, 9, 0, 6, -1, 0, 9);

    // R3: back-to-back characters, no idle time
    len_sel = 2'b01;
    for (int i = 0; i < 6; i++) begin
      d = 9'($urandom);
      rx_check("R3 back-to-back", d, 8, 0, 0, -1, -1, 8);
    end
    wait_ticks(8);

    // R3 R5 R7: random characters
    for (int i = 0; i < 100; i++) begin
      nb  = 7 + int'($urandom % 3);
      d   = 9'($urandom);
      bad = (($urandom % 10) == 0);
      len_sel = sel_for(nb, 1'($urandom));
      rx_check("R3 random", d, nb, bad, bad ? 4 + int'($urandom % 8) : int'($urandom % 12),
               -1, -1, nb);
    end

    wait_ticks(10);
    chk("R6 never two-cycle strobe", 32'(n_dbl), 0);
    chk("R7 no lone ferr", 32'(n_orph), 0);
    finish_run();
  end

endmodule